// File: doc/BRIEF.md
# SDRAM Address Mux and Command Sequencer

This block sits between a 64-bit-wide system bus and one SDRAM device group. It breaks each bus address into column, internal bank and row fields for page-interleaved access, where the bank bits sit just above the column field and just below the row field. It also drives the device control pins for every access.

A three-bit mode input selects what an accepted request does. In normal mode a request runs a complete page cycle: activate, then read or write, then precharge of that bank. The gaps between these commands come from timing inputs. In the other modes a request issues exactly one command: precharge of all banks, auto refresh, or a load of the device's mode register. Software brings the device up by using these modes in turn: precharge-all, eight or more refreshes, then the mode-register load, and then normal mode.

The A10 address line has its own output pin with its own multiplexer. During activate it carries row bit 10. During the column and precharge phases it carries the precharge-scope control. A one-cycle acknowledge tells the bus that read data is valid, that write data is being taken, or that a single command has gone out. Requests are sampled only while the sequencer is idle.

Top module: `sdr_mux_seq`

## Requirements
- R1: While `rst_n` is low, all four command pins are high and `ack` is low. In every idle cycle after reset, the pins show NOP.
- R2: Using LSB-0 bit numbering, the column is `addr[11:3]`, the bank is `addr[13:12]` and the row is `addr[25:14]`. `addr[2:0]` has no effect on any pin.
- R3: For an activate command, `sd_addr` carries the row with bit 10 forced to 0, `sd_a10` carries row bit 10 (`addr[24]`), and `sd_ba` carries the bank.
- R4: In normal mode (`mode`=000), the column command comes exactly `trcd` cycles after the activate, with 0 treated as 1. It is a READ when `rw`=1 and a WRITE when `rw`=0. It drives the column on `sd_addr[8:0]`, zeros on the other address bits, `sd_a10`=0, and the bank of the activate.
- R5: After a READ, `ack` is a one-cycle pulse exactly CL=2 cycles after the READ command.
- R6: After a READ, a single-bank PRECHARGE (`sd_a10`=0, same bank) follows at READ + CL + BL − 1 + `tldo` cycles, with BL=4.
- R7: A WRITE asserts `ack` in the same cycle as the WRITE command. A single-bank PRECHARGE follows at WRITE + BL − 1 + `twr` cycles.
- R8: After any precharge or single command, the next command comes no earlier than `trp` cycles later. A request held high across this gap gets its activate exactly `trp` cycles after the precharge.
- R9: Mode 101 issues one PRECHARGE with `sd_a10`=1, `sd_addr`=0 and `sd_ba`=0. `ack` is high in the same cycle.
- R10: Mode 001 issues one REFRESH with `sd_addr`=0 and `sd_ba`=0. `ack` is high in the same cycle.
- R11: Mode 011 issues one MODE REGISTER SET with `sd_addr`=0x022 (burst length 4 coded as 010 in bits 2:0, sequential burst, CAS latency 2 in bits 6:4), `sd_a10`=0 and `sd_ba`=0. `ack` is high in the same cycle.
- R12: Modes 010, 100, 110 and 111 issue no command (the pins stay at NOP) but still pulse `ack` once.
- R13: Commands are coded on {`sd_cs_n`,`sd_ras_n`,`sd_cas_n`,`sd_we_n`} as: NOP 0111, ACTIVATE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, REFRESH 0001, MODE REGISTER SET 0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, sampled while idle |
| rw | input | 1 | 1 = read, 0 = write (normal mode) |
| mode | input | 3 | Access mode select |
| trcd | input | 3 | Activate to column command, in cycles |
| tldo | input | 3 | Last read data to precharge, in cycles |
| twr | input | 3 | Write recovery, in cycles |
| trp | input | 3 | Precharge to next command, in cycles |
| addr | input | 32 | Bus byte address |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | 12 | Multiplexed address, bit 10 held 0 |
| sd_a10 | output | 1 | A10 / precharge-scope pin |
| sd_ba | output | 2 | Internal bank select |
| ack | output | 1 | Data valid / command acknowledge |

## Verification
The bench uses the default geometry: 9 column bits, 4 banks, 12 row bits, CL 2 and BL 4. With 3-bit timing inputs, every combination of `trcd` 0–3, `tldo` 1–2, `twr` 1–2 and `trp` 1–3 can be swept for both reads and writes. Each transaction uses a different arithmetic address pattern, so every bank, the A10 row bit in both states, and nonzero byte-offset bits all occur. It also covers the zero-to-one clamp on `trcd` and back-to-back requests that land exactly on the precharge gap. Each single-command mode and each reserved mode code is also run, so every mode value is covered.

// File: rtl/sdr_pkg.sv
package sdr_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS   = 4'b0000,
    CMD_REF   = 4'b0001,
    CMD_PRE   = 4'b0010,
    CMD_ACT   = 4'b0011,
    CMD_WR    = 4'b0100,
    CMD_RD    = 4'b0101,
    CMD_NOP   = 4'b0111,
    CMD_DESEL = 4'b1111
  } sdr_cmd_e;

  // what the address multiplexer places on the pins
  typedef enum logic [2:0] {
    PH_ZERO = 3'd0,
    PH_ROW  = 3'd1,
    PH_COL  = 3'd2,
    PH_MODE = 3'd3,
    PH_BANK = 3'd4
  } sdr_phase_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } sdr_state_e;

  typedef enum logic [1:0] {
    NX_COL  = 2'd0,
    NX_PRE  = 2'd1,
    NX_IDLE = 2'd2
  } sdr_next_e;

  localparam logic [2:0] MODE_NORM = 3'b000;
  localparam logic [2:0] MODE_REF  = 3'b001;
  localparam logic [2:0] MODE_MRS  = 3'b011;
  localparam logic [2:0] MODE_PALL = 3'b101;

endpackage

// File: rtl/sdr_addr_map.sv
module sdr_addr_map
  import sdr_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_BYTES = 8,
  parameter int COL_W      = 9,
  parameter int BANK_W     = 2,
  parameter int ROW_W      = 12,
  parameter int AP_BIT     = 10,
  parameter int CL         = 2,
  parameter int BL         = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  sdr_phase_e        phase,
  input  logic              ap_ctl,
  output logic [ROW_W-1:0]  pin_addr,
  output logic              pin_a10,
  output logic [BANK_W-1:0] pin_bank
);

  localparam int COL_LSB  = $clog2(DATA_BYTES);
  localparam int BANK_LSB = COL_LSB + COL_W;
  localparam int ROW_LSB  = BANK_LSB + BANK_W;
  localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'((CL << 4) | $clog2(BL));
  localparam logic [ROW_W-1:0] AP_MASK   = ~(ROW_W'(1) << AP_BIT);

  logic [COL_W-1:0]  col_f;
  logic [BANK_W-1:0] bank_f;
  logic [ROW_W-1:0]  row_f;
  logic [ROW_W-1:0]  full;

  assign col_f  = addr[COL_LSB +: COL_W];
  assign bank_f = addr[BANK_LSB +: BANK_W];
  assign row_f  = addr[ROW_LSB +: ROW_W];

  always_comb begin
    full     = '0;
    pin_bank = '0;
    unique case (phase)
      PH_ROW:  begin full = row_f;            pin_bank = bank_f; end
      PH_COL:  begin full = ROW_W'(col_f);    pin_bank = bank_f; end
      PH_MODE: begin full = MODE_WORD;                           end
      PH_BANK: begin                          pin_bank = bank_f; end
      default: begin                                             end
    endcase
  end

  // A10 carries a row/mode bit only when the address is a row or mode word
  assign pin_a10  = (phase == PH_ROW || phase == PH_MODE) ? full[AP_BIT] : ap_ctl;
  assign pin_addr = full & AP_MASK;

endmodule

// File: rtl/sdr_cmd_seq.sv
module sdr_cmd_seq
  import sdr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TW     = 3,
  parameter int CL     = 2,
  parameter int BL     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              rw,
  input  logic [2:0]        mode,
  input  logic [TW-1:0]     trcd,
  input  logic [TW-1:0]     tldo,
  input  logic [TW-1:0]     twr,
  input  logic [TW-1:0]     trp,
  input  logic [ADDR_W-1:0] bus_addr,
  output sdr_cmd_e          cmd_nxt,
  output sdr_phase_e        phase_nxt,
  output logic              ap_nxt,
  output logic [ADDR_W-1:0] addr_use,
  output logic              ack
);

  localparam int CW = $clog2(CL + BL + (1 << TW)) + 1;
  localparam int AW = $clog2(CL + 1);

  sdr_state_e        state_q, state_n;
  sdr_next_e         nx_q, nx_n;
  logic [CW-1:0]     cnt_q, cnt_n;
  logic [AW-1:0]     ackc_q, ackc_n;
  logic              ack_q, ack_n;
  logic [ADDR_W-1:0] addr_q;
  logic              rw_q;
  logic              lat_en;

  logic [CW-1:0] t_rcd, t_rp, t_rd_pre, t_wr_pre;

  assign t_rcd    = (trcd == '0) ? CW'(1) : CW'(trcd);
  assign t_rp     = (trp  == '0) ? CW'(1) : CW'(trp);
  assign t_rd_pre = CW'(CL + BL - 1) + ((tldo == '0) ? CW'(1) : CW'(tldo));
  assign t_wr_pre = CW'(BL - 1)      + ((twr  == '0) ? CW'(1) : CW'(twr));

  assign lat_en = (state_q == ST_IDLE) && req;

  always_comb begin
    state_n   = state_q;
    nx_n      = nx_q;
    cnt_n     = cnt_q;
    cmd_nxt   = CMD_NOP;
    phase_nxt = PH_ZERO;
    ap_nxt    = 1'b0;
    addr_use  = addr_q;
    ackc_n    = (ackc_q != '0) ? ackc_q - AW'(1) : '0;
    ack_n     = (ackc_q == AW'(1));

    unique case (state_q)
      ST_IDLE: if (req) begin
        addr_use = bus_addr;
        if (mode == MODE_NORM) begin
          cmd_nxt   = CMD_ACT;
          phase_nxt = PH_ROW;
          state_n   = ST_WAIT;
          nx_n      = NX_COL;
          cnt_n     = t_rcd;
        end else begin
          ack_n = 1'b1;
          unique case (mode)
            MODE_PALL: begin cmd_nxt = CMD_PRE; ap_nxt = 1'b1; end
            MODE_REF:  cmd_nxt = CMD_REF;
            MODE_MRS:  begin cmd_nxt = CMD_MRS; phase_nxt = PH_MODE; end
            default:   cmd_nxt = CMD_NOP;
          endcase
          // recovery: idle is reached so a new request lands at trp
          state_n = (t_rp > CW'(1)) ? ST_WAIT : ST_IDLE;
          nx_n    = NX_IDLE;
          cnt_n   = t_rp - CW'(1);
        end
      end
      ST_WAIT: begin
        if (cnt_q > CW'(1)) begin
          cnt_n = cnt_q - CW'(1);
        end else begin
          unique case (nx_q)
            NX_COL: begin
              cmd_nxt   = rw_q ? CMD_RD : CMD_WR;
              phase_nxt = PH_COL;
              nx_n      = NX_PRE;
              if (rw_q) begin
                ackc_n = AW'(CL);
                cnt_n  = t_rd_pre;
              end else begin
                ack_n  = 1'b1;
                cnt_n  = t_wr_pre;
              end
            end
            NX_PRE: begin
              cmd_nxt   = CMD_PRE;
              phase_nxt = PH_BANK;
              state_n   = (t_rp > CW'(1)) ? ST_WAIT : ST_IDLE;
              nx_n      = NX_IDLE;
              cnt_n     = t_rp - CW'(1);
            end
            default: state_n = ST_IDLE;
          endcase
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      nx_q    <= NX_IDLE;
      cnt_q   <= '0;
      ackc_q  <= '0;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      nx_q    <= nx_n;
      cnt_q   <= cnt_n;
      ackc_q  <= ackc_n;
      ack_q   <= ack_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rw_q   <= 1'b0;
    end else if (lat_en) begin
      addr_q <= bus_addr;
      rw_q   <= rw;
    end
  end

  assign ack = ack_q;

  // a waiting sequencer always has a live interval count (R8)
  p_wait_count_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT) |-> (cnt_q != '0));

endmodule

// File: rtl/sdr_mux_seq.sv
module sdr_mux_seq
  import sdr_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_BYTES = 8,
  parameter int COL_W      = 9,
  parameter int BANK_W     = 2,
  parameter int ROW_W      = 12,
  parameter int AP_BIT     = 10,
  parameter int CL         = 2,
  parameter int BL         = 4,
  parameter int TW         = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              rw,
  input  logic [2:0]        mode,
  input  logic [TW-1:0]     trcd,
  input  logic [TW-1:0]     tldo,
  input  logic [TW-1:0]     twr,
  input  logic [TW-1:0]     trp,
  input  logic [ADDR_W-1:0] addr,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ROW_W-1:0]  sd_addr,
  output logic              sd_a10,
  output logic [BANK_W-1:0] sd_ba,
  output logic              ack
);

  localparam int GW = TW + 1;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  sdr_cmd_e          cmd_nxt, cmd_q;
  sdr_phase_e        phase_nxt;
  logic              ap_nxt;
  logic [ADDR_W-1:0] addr_use;
  logic [ROW_W-1:0]  map_addr;
  logic              map_a10;
  logic [BANK_W-1:0] map_bank;
  logic              pin_en;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sdr_cmd_seq #(
    .ADDR_W(ADDR_W), .TW(TW), .CL(CL), .BL(BL)
  ) u_seq (
    .clk(clk), .rst_n(rst_int_n), .req(req), .rw(rw), .mode(mode),
    .trcd(trcd), .tldo(tldo), .twr(twr), .trp(trp), .bus_addr(addr),
    .cmd_nxt(cmd_nxt), .phase_nxt(phase_nxt), .ap_nxt(ap_nxt),
    .addr_use(addr_use), .ack(ack)
  );

  sdr_addr_map #(
    .ADDR_W(ADDR_W), .DATA_BYTES(DATA_BYTES), .COL_W(COL_W), .BANK_W(BANK_W),
    .ROW_W(ROW_W), .AP_BIT(AP_BIT), .CL(CL), .BL(BL)
  ) u_map (
    .addr(addr_use), .phase(phase_nxt), .ap_ctl(ap_nxt),
    .pin_addr(map_addr), .pin_a10(map_a10), .pin_bank(map_bank)
  );

  assign pin_en = (cmd_nxt != CMD_NOP);

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cmd_q   <= CMD_DESEL;
      sd_addr <= '0;
      sd_a10  <= 1'b0;
      sd_ba   <= '0;
    end else begin
      cmd_q <= cmd_nxt;
      if (pin_en) begin
        sd_addr <= map_addr;
        sd_a10  <= map_a10;
        sd_ba   <= map_bank;
      end
    end
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;

  // ---- checking state ----
  logic [GW-1:0]     gap_q;
  logic [BANK_W-1:0] act_bank_q;
  logic [GW-1:0]     rcd_eff;

  assign rcd_eff = (trcd == '0) ? GW'(1) : GW'(trcd);

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      gap_q      <= '0;
      act_bank_q <= '0;
    end else begin
      if (cmd_q == CMD_ACT) begin
        gap_q      <= GW'(1);
        act_bank_q <= sd_ba;
      end else if (gap_q != '1) begin
        gap_q <= gap_q + GW'(1);
      end
    end
  end

  p_rcd_gap_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmd_q == CMD_RD || cmd_q == CMD_WR) |-> (gap_q == rcd_eff));

  p_col_a10_low_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmd_q == CMD_RD || cmd_q == CMD_WR) |-> !sd_a10);

  p_bank_kept_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmd_q == CMD_RD || cmd_q == CMD_WR || (cmd_q == CMD_PRE && !sd_a10))
      |-> (sd_ba == act_bank_q));

  p_single_ack_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmd_q == CMD_REF || cmd_q == CMD_MRS) |-> ack);

endmodule

// File: tb/sdr_mux_seq_tb.sv
module sdr_mux_seq_tb;

  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                         C_WR = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001,
                         C_MRS = 4'b0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req, rw;
  logic [2:0]  mode;
  logic [2:0]  trcd, tldo, twr, trp;
  logic [31:0] addr;
  logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_a10, ack;
  logic [11:0] sd_addr;
  logic [1:0]  sd_ba;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  sdr_mux_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .rw(rw), .mode(mode),
    .trcd(trcd), .tldo(tldo), .twr(twr), .trp(trp), .addr(addr),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_addr(sd_addr), .sd_a10(sd_a10), .sd_ba(sd_ba),
    .ack(ack)
  );

  function automatic logic [3:0] cmd_now();
    return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic do_normal(input logic [31:0] a, input bit rd, input int rcd,
                           input int ldo, input int wr, input int rp, input bit keep);
    int t_act, t_col, t_ack, t_pre, t_act2, rcd_e;
    logic [3:0] c;
    int row, col, bnk;
    row = int'((a >> 14) & 32'hFFF);
    col = int'((a >> 3) & 32'h1FF);
    bnk = int'((a >> 12) & 32'h3);
    rcd_e = (rcd == 0) ? 1 : rcd;
    t_act = -1; t_col = -1; t_ack = -1; t_pre = -1; t_act2 = -1;
    mode = 3'b000; rw = rd; addr = a;
    trcd = 3'(rcd); tldo = 3'(ldo); twr = 3'(wr); trp = 3'(rp);
    req = 1'b1;
    for (int k = 0; k < 80; k++) begin
      @(negedge clk);
      c = cmd_now();
      if (ack && t_ack < 0) t_ack = k;
      if (c == C_ACT) begin
        if (t_act < 0) begin
          t_act = k;
          chk(sd_addr == 12'(row & ~(1 << 10)), "R3 row addr", int'(sd_addr), row & ~(1 << 10));
          chk(sd_a10 == a[24], "R3 a10 row bit", int'(sd_a10), int'(a[24]));
          chk(sd_ba == 2'(bnk), "R2 bank", int'(sd_ba), bnk);
          if (!keep) req = 1'b0;
        end else if (t_pre >= 0 && t_act2 < 0) begin
          t_act2 = k;
          req = 1'b0;
        end
      end else if (c == C_RD || c == C_WR) begin
        if (t_col < 0) begin
          t_col = k;
          chk(c == (rd ? C_RD : C_WR), "R13 column cmd code", int'(c), int'(rd ? C_RD : C_WR));
          chk(sd_addr == 12'(col), "R2 column addr", int'(sd_addr), col);
          chk(sd_a10 == 1'b0 && sd_ba == 2'(bnk), "R4 a10/bank", int'({sd_a10, sd_ba}), bnk);
        end
      end else if (c == C_PRE) begin
        if (t_pre < 0) begin
          t_pre = k;
          chk(sd_a10 == 1'b0 && sd_ba == 2'(bnk), "R6 single-bank precharge", int'({sd_a10, sd_ba}), bnk);
        end
      end else begin
        chk(c == C_NOP, "R1 idle NOP", int'(c), int'(C_NOP));
      end
      if (!keep && t_pre >= 0 && k >= t_pre + rp + 1) break;
      if (keep && t_act2 >= 0) break;
    end
    chk(t_col - t_act == rcd_e, "R4 activate-to-column", t_col - t_act, rcd_e);
    if (rd) begin
      chk(t_ack - t_col == 2, "R5 read ack", t_ack - t_col, 2);
      chk(t_pre - t_col == 5 + ldo, "R6 read-to-precharge", t_pre - t_col, 5 + ldo);
    end else begin
      chk(t_ack == t_col, "R7 write ack", t_ack - t_col, 0);
      chk(t_pre - t_col == 3 + wr, "R7 write-to-precharge", t_pre - t_col, 3 + wr);
    end
    if (keep) begin
      chk(t_act2 - t_pre == rp, "R8 precharge-to-activate", t_act2 - t_pre, rp);
      repeat (40) @(negedge clk);
    end
  endtask

  task automatic do_single(input logic [2:0] m, input logic [3:0] ecmd,
                           input int eaddr, input bit ea10, input string rq);
    bit seen;
    int extra;
    logic [3:0] c;
    seen = 0; extra = 0;
    mode = m; trp = 3'd2; addr = 32'hFFFF_FFFF; req = 1'b1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      c = cmd_now();
      if (c != C_NOP || ack) begin
        if (!seen) begin
          seen = 1;
          req = 1'b0;
          chk(c == ecmd, rq, int'(c), int'(ecmd));
          chk(ack == 1'b1, rq, int'(ack), 1);
          if (ecmd != C_NOP) begin
            chk(sd_addr == 12'(eaddr), rq, int'(sd_addr), eaddr);
            chk(sd_a10 == ea10, rq, int'(sd_a10), int'(ea10));
            chk(sd_ba == 2'd0, rq, int'(sd_ba), 0);
          end
        end else begin
          extra++;
        end
      end
    end
    chk(seen, rq, int'(seen), 1);
    chk(extra == 0, rq, extra, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int i;
    rst_n = 1'b0; req = 1'b0; rw = 1'b0; mode = 3'b000; addr = '0;
    trcd = 3'd2; tldo = 3'd1; twr = 3'd1; trp = 3'd3;
    repeat (3) @(negedge clk);
    chk(cmd_now() == 4'b1111, "R1 reset pins", int'(cmd_now()), 15);
    chk(ack == 1'b0, "R1 reset ack", int'(ack), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(cmd_now() == C_NOP, "R1 idle NOP", int'(cmd_now()), int'(C_NOP));

    // initialization order, then normal operation
    do_single(3'b101, C_PRE, 0, 1'b1, "R9 precharge all");
    for (int r = 0; r < 8; r++) do_single(3'b001, C_REF, 0, 1'b0, "R10 refresh");
    do_single(3'b011, C_MRS, 32'h022, 1'b0, "R11 mode register set");

    i = 0;
    for (int rd = 0; rd < 2; rd++)
      for (int rcd = 0; rcd < 4; rcd++)
        for (int ldo = 1; ldo < 3; ldo++)
          for (int wr = 1; wr < 3; wr++)
            for (int rp = 1; rp < 4; rp++) begin
              logic [31:0] a;
              a = (32'((i * 397 + 5) & 32'hFFF) << 14) | (32'(i & 3) << 12) |
                  (32'((i * 37 + 1) & 32'h1FF) << 3) | 32'(i & 7) |
                  (32'(i & 32'h3F) << 26);
              do_normal(a, rd[0], rcd, ldo, wr, rp, (i % 5) == 0);
              i++;
            end
    do_normal(32'hFFFF_FFFF, 1'b1, 2, 1, 1, 3, 1'b0);
    do_normal(32'h0000_0000, 1'b0, 2, 1, 1, 3, 1'b0);
    do_normal(32'h0100_0000, 1'b1, 3, 2, 2, 2, 1'b1);

    do_single(3'b010, C_NOP, 0, 1'b0, "R12 reserved mode 010");
    do_single(3'b100, C_NOP, 0, 1'b0, "R12 reserved mode 100");
    do_single(3'b110, C_NOP, 0, 1'b0, "R12 reserved mode 110");
    do_single(3'b111, C_NOP, 0, 1'b0, "R12 reserved mode 111");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule